// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block is a write-only two-wire serial bus target that sets seven 8-bit control registers for a stereo audio processor. A host controller opens a transfer with a START, sends the device address byte, then one register-select byte, then one or more data bytes. The block ACKs each byte by pulling SDA low during the ninth clock, and ends the transfer on STOP. The select byte sets an internal pointer. Each data byte is written at the pointer, and the pointer then moves up by one. Only the first byte after the address is ever treated as a select. Every later byte is data.

SCL and SDA pass through a two-stage synchronizer on the system clock. The system clock must run at least 20 times faster than SCL. The synchronized levels feed an edge detector that produces SCL rise and fall pulses and START and STOP events. A receive state machine has the states IDLE, ADDR, ADDR_ACK, PTR, PTR_ACK, DATA, DATA_ACK and IGNORE. Its transitions are:

- START from any state goes to ADDR. STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on a matching address byte, and to IGNORE on any other.
- ADDR_ACK goes to PTR, PTR_ACK goes to DATA, and DATA_ACK goes back to DATA. Each of these steps happens on the SCL fall that ends the ACK bit.
- PTR goes to PTR_ACK, and DATA goes to DATA_ACK, on the SCL fall after the eighth bit.

The registers appear as parallel outputs. Bit 5 of the flag register also drives a single logic-level auxiliary pin.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: An address byte of 0x82 (7-bit address 1000001, R/W = 0) is acknowledged: `sda_oe` is 1 while SCL is high for the ninth bit. `sda_oe` only changes while the synchronized SCL is low.
- R2: An address byte other than 0x82 gets no ACK. This includes 0x83, which has R/W = 1. Every byte that follows it, up to the next START, is ignored: no ACK and no register change.
- R3: After a matching address, the next byte is acknowledged and loaded as the register pointer. Register map: 0 is left volume, 1 is right volume, 2 is bass, 3 is treble, 4 is surround, 5 is effect control and 6 is the flag register.
- R4: Data byte n of a transfer is written to register (pointer + n − 1). Each data byte is acknowledged, and each byte causes at most one register write.
- R5: Only the first byte after the address is a select. A later byte equal to 0x82, or to any select value, is stored as data at the current pointer.
- R6: A pointer above 6, or one that has advanced past 6, still ACKs data bytes but writes nothing.
- R7: Reset values are left and right volume 0x00 (fully attenuated), bass and treble 0x20, surround 0x00, effect control 0x00 and flags 0x00. `aux_out` is 0 and `sda_oe` is 0.
- R8: `aux_out` equals bit 5 of the flag register (register 6). The effect register holds its enable flags in bits 7..4 and its level in bits 3..0, and it is passed out unchanged.
- R9: A repeated START inside a transfer makes the next byte an address byte again. The select and data bytes that follow then apply as in a fresh transfer.
- R10: STOP returns the block to idle and releases SDA. Bytes clocked afterwards with no START get no ACK and write nothing.
- R11: A data byte cut short by STOP, before its eighth bit, writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20× SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND line) |
| sda_oe | output | 1 | 1 = pull SDA low (ACK) |
| vol_left | output | 8 | Left volume, 0xFF = 0 dB, 0x00 = mute |
| vol_right | output | 8 | Right volume, same coding |
| bass_lvl | output | 8 | Bass tone code |
| treble_lvl | output | 8 | Treble tone code |
| surround_lvl | output | 8 | Surround register |
| effect_ctl | output | 8 | Effect enables [7:4], level [3:0] |
| flag_ctl | output | 8 | Flag register (mute, AGC, bass mix, aux) |
| aux_out | output | 1 | Auxiliary logic level, flag bit 5 |

## Verification
The bench targets the pointer running off the end of the map, a data byte that repeats the device address, and a select value beyond the map. A design that wraps the pointer, that re-reads a select byte, or that writes an out-of-range register would leave a register value that differs from the bench's model. It also sends a wrong address, a read-direction address, a repeated START, bytes clocked after STOP, and a half byte cut short by STOP. A slave that ACKed too readily, failed to restart its byte count, or committed partial bytes would show a wrong ACK level or a changed register.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 7;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // idle bus is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
    import audio_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data
);
    localparam int CNT_W = $clog2(REG_W + 1);
    localparam logic [REG_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    rx_state_e        state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [REG_W-1:0] shreg;
    logic [REG_W-1:0] ptr;
    logic             byte_done;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(REG_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_ADDR:     if (byte_done)
                             nxt = (shreg == ADDR_BYTE) ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK: if (scl_fall) nxt = ST_PTR;
            ST_PTR:      if (byte_done) nxt = ST_PTR_ACK;
            ST_PTR_ACK:  if (scl_fall) nxt = ST_DATA;
            ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
            ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
            ST_IGNORE:   nxt = ST_IGNORE;
        endcase
        if (start_evt)     nxt = ST_ADDR;
        else if (stop_evt) nxt = ST_IDLE;
    end

    always_comb begin
        sda_oe = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) ||
                 (state == ST_DATA_ACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt || stop_evt) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[REG_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_done && state == ST_PTR)
                            ptr <= shreg;
                        if (byte_done && state == ST_DATA &&
                            ptr < REG_W'(NUM_REGS)) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr[ADDR_W-1:0];
                            wr_data <= shreg;
                            ptr     <= ptr + 1'b1;
                        end
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_IDLE, ST_IGNORE: bit_cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import audio_i2c_pkg::*;
#(
    parameter logic [NUM_REGS*REG_W-1:0] RST_VALS = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_flat[i*REG_W +: REG_W] <= RST_VALS[i*REG_W +: REG_W];
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs_flat[i*REG_W +: REG_W] <= wr_data;
        end
    end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
    import audio_i2c_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR    = 7'h41,
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] TONE_RESET  = 8'h20,
    parameter int               AUX_BIT     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [REG_W-1:0] vol_left,
    output logic [REG_W-1:0] vol_right,
    output logic [REG_W-1:0] bass_lvl,
    output logic [REG_W-1:0] treble_lvl,
    output logic [REG_W-1:0] surround_lvl,
    output logic [REG_W-1:0] effect_ctl,
    output logic [REG_W-1:0] flag_ctl,
    output logic             aux_out
);
    localparam logic [NUM_REGS*REG_W-1:0] RST_VALS =
        {8'h00, 8'h00, 8'h00, TONE_RESET, TONE_RESET, 8'h00, 8'h00};

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic                      wr_en;
    logic [ADDR_W-1:0]         wr_addr;
    logic [REG_W-1:0]          wr_data;
    logic [NUM_REGS*REG_W-1:0] regs_flat;

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    rx_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    reg_bank #(.RST_VALS(RST_VALS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    assign vol_left     = regs_flat[0*REG_W +: REG_W];
    assign vol_right    = regs_flat[1*REG_W +: REG_W];
    assign bass_lvl     = regs_flat[2*REG_W +: REG_W];
    assign treble_lvl   = regs_flat[3*REG_W +: REG_W];
    assign surround_lvl = regs_flat[4*REG_W +: REG_W];
    assign effect_ctl   = regs_flat[5*REG_W +: REG_W];
    assign flag_ctl     = regs_flat[6*REG_W +: REG_W];
    assign aux_out      = flag_ctl[AUX_BIT];
endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk
    import audio_i2c_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sda_oe,
    input logic                      scl_lvl,
    input logic                      stop_evt,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [NUM_REGS*REG_W-1:0] regs_flat
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_lvl); // R1

    AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat)); // R2

    AST_ONE_WRITE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4

    AST_WRITE_INSIDE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < ADDR_W'(NUM_REGS))); // R6

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe); // R10
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
    .stop_evt(stop_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .regs_flat(regs_flat)
);

// File: tb/tb_audio_ctl_i2c_slave.sv
module tb_audio_ctl_i2c_slave;
    localparam int Q = 20;     // system clocks per SCL quarter step
    localparam int NV = 8;

    // {address, select, count, d0, d1, d2}
    localparam logic [42:0] VECS [NV] = '{
        {8'h82, 8'h00, 3'd1, 8'h7F, 8'h00, 8'h00},   // R3 left volume
        {8'h82, 8'h02, 3'd3, 8'h11, 8'h22, 8'h33},   // R4 auto-increment
        {8'h82, 8'h05, 3'd3, 8'h9A, 8'h21, 8'h82},   // R6 run off end, R8
        {8'h82, 8'h00, 3'd2, 8'h55, 8'h82, 8'h00},   // R5 address-like data
        {8'h84, 8'h00, 3'd1, 8'hAA, 8'h00, 8'h00},   // R2 wrong address
        {8'h83, 8'h01, 3'd1, 8'h44, 8'h00, 8'h00},   // R2 read direction
        {8'h82, 8'h09, 3'd2, 8'h12, 8'h34, 8'h00},   // R6 select beyond map
        {8'h82, 8'h06, 3'd1, 8'h00, 8'h00, 8'h00}    // R8 aux low again
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, aux_out;
    logic [7:0] vol_left, vol_right, bass_lvl, treble_lvl;
    logic [7:0] surround_lvl, effect_ctl, flag_ctl;
    wire  sda_line = sda_h & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_r [7];

    always #5 clk = ~clk;

    audio_ctl_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe(sda_oe), .vol_left(vol_left), .vol_right(vol_right),
        .bass_lvl(bass_lvl), .treble_lvl(treble_lvl),
        .surround_lvl(surround_lvl), .effect_ctl(effect_ctl),
        .flag_ctl(flag_ctl), .aux_out(aux_out)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp,
                       input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        logic [7:0] got [7];
        got = '{vol_left, vol_right, bass_lvl, treble_lvl,
                surround_lvl, effect_ctl, flag_ctl};
        for (int i = 0; i < 7; i++)
            chk(got[i], exp_r[i], req, $sformatf("reg%0d", i));
        chk({7'd0, aux_out}, {7'd0, exp_r[6][5]}, req, "aux_out");
    endtask

    task automatic bus_start;   // works from idle or with SCL low
        sda_h = 1'b1; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b1; wt(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_h = b[i]; wt(Q);
            scl_h = 1'b1; wt(Q);
            scl_h = 1'b0; wt(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_h = 1'b1; wt(Q);
        scl_h = 1'b1; wt(Q / 2);
        ack = ~sda_line;
        wt(Q / 2);
        scl_h = 1'b0; wt(Q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        exp_r = '{8'h00, 8'h00, 8'h20, 8'h20, 8'h00, 8'h00, 8'h00};
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R7: reset state
        check_regs("R7");
        chk({7'd0, sda_oe}, 8'h00, "R7", "sda_oe");

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [7:0] a, p;
            int n;
            logic [7:0] d [3];
            logic ok;
            a = VECS[v][42:35];
            p = VECS[v][34:27];
            n = int'(VECS[v][26:24]);
            d = '{VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]};
            ok = (a == 8'h82);
            bus_start;
            send_byte(a, ack);
            chk({7'd0, ack}, {7'd0, ok}, ok ? "R1" : "R2", "address ack");
            send_byte(p, ack);
            chk({7'd0, ack}, {7'd0, ok}, ok ? "R3" : "R2", "select ack");
            for (int k = 0; k < n; k++) begin
                send_byte(d[k], ack);
                chk({7'd0, ack}, {7'd0, ok}, ok ? "R4" : "R2", "data ack");
                if (ok && (int'(p) + k) < 7) exp_r[int'(p) + k] = d[k];
            end
            bus_stop;
            check_regs(ok ? "R4 R5 R6 R8" : "R2");
        end

        // R9: repeated START, select 3 abandoned, then select 4
        bus_start;
        send_byte(8'h82, ack);
        send_byte(8'h03, ack);
        bus_start;
        send_byte(8'h82, ack);
        chk({7'd0, ack}, 8'h01, "R9", "address ack after restart");
        send_byte(8'h04, ack);
        send_byte(8'h5C, ack);
        bus_stop;
        exp_r[4] = 8'h5C;
        check_regs("R9");

        // R11: half a data byte then STOP
        bus_start;
        send_byte(8'h82, ack);
        send_byte(8'h01, ack);
        send_bits(8'hF0, 4);
        bus_stop;
        check_regs("R11");

        // R10: bytes clocked after STOP without START
        scl_h = 1'b0; wt(Q);
        send_byte(8'h82, ack);
        chk({7'd0, ack}, 8'h00, "R10", "ack without start");
        send_byte(8'h01, ack);
        send_byte(8'hEE, ack);
        chk({7'd0, ack}, 8'h00, "R10", "data ack without start");
        bus_stop;
        check_regs("R10");

        // R8: aux high via single write to flags
        bus_start;
        send_byte(8'h82, ack);
        send_byte(8'h06, ack);
        send_byte(8'h20, ack);
        bus_stop;
        exp_r[6] = 8'h20;
        check_regs("R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule